// File: doc/BRIEF.md
# Iterative AES Encryption Round Engine

This block encrypts one 128-bit block at a time with AES. It computes one whole cipher round per clock cycle, so a block needs 10, 12 or 14 round cycles plus one cycle for the initial key addition. The key size is fixed when the block is elaborated (`KEY_BITS` = 128, 192 or 256). Key expansion happens outside the block. An external round-key store answers the registered index `rk_idx` with the matching 128-bit key on `round_key` in the same cycle.

A block starts only when three conditions hold together: the plaintext is stable, the key is stable, and the key generator reports that every round key is ready. The plaintext is captured on the clock edge where the start conditions are met. From then on the engine runs to completion. The block has no back-pressure. No new start is taken until the engine is idle again, and flags or data presented while it is busy are ignored. The ciphertext stays in a result register until the next block finishes. A one-cycle `done` pulse marks each completion. Every output comes from a register.

Top module: `aes_enc_core`

## Requirements
- R1: `result` equals the AES encryption of the captured plaintext under the round keys supplied for indices 0..NR, where NR = KEY_BITS/32+6. Byte 0 of the block is bits [127:120], and the state is filled column by column with four bytes per column.
- R2: A block starts only on a rising clock edge where `data_stable`, `key_stable` and `key_ready` are all high while the engine is idle. If any of them is low, `rk_idx` stays 0 and `done` stays low.
- R3: `done` is high for exactly one cycle. It goes high on the (NR+1)-th rising edge after the start edge, and on that same edge `result` is updated.
- R4: `rk_idx` is 0 while idle and during the initial key addition. After the k-th edge following the start edge, it equals k for k = 1..NR. It returns to 0 when `done` goes high.
- R5: `plaintext` is captured on the start edge. Any later change to `plaintext` or to the flags has no effect on the block in progress.
- R6: `result` is never cleared. It keeps its value until the next block completes.
- R7: After reset, `done` is 0, `rk_idx` is 0 and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| plaintext | input | 128 | Block to encrypt, captured at start |
| data_stable | input | 1 | Plaintext is valid and stable |
| key_stable | input | 1 | Key is valid and stable |
| key_ready | input | 1 | All round keys are present in the key store |
| round_key | input | 128 | Round key read from the store at `rk_idx` |
| rk_idx | output | $clog2(NR+1) | Round counter, used as the key-store address |
| result | output | 128 | Registered ciphertext |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench drives its inputs and samples the outputs on falling edges, and it counts rising edges from the one that met the start conditions. The count fixes when each output is due:
- `rk_idx` must read k after edge k, for k = 1..NR.
- `done` must be low for the first NR edges, high after edge NR+1, and low again after edge NR+2.
- `result` is compared at edge NR+1, with the expected value taken from the bench's own S-box, key schedule and cipher model.

As soon as the start edge has passed, the plaintext is inverted and the flags are dropped, which shows that the block in progress is not disturbed. Idle stretches with one start flag held low, and long pauses after completion, check that nothing moves when it should not.

// File: rtl/aes_enc_pkg.sv
package aes_enc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_INIT, ST_ROUNDS, ST_LAST, ST_DONE
  } aes_st_e;

  function automatic logic [7:0] gf_xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] aa;
    acc = 8'h00;
    aa  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ aa;
      aa = gf_xtime(aa);
    end
    return acc;
  endfunction

  // Substitution: inverse as x^254, then the affine map
  function automatic logic [7:0] sub_byte(input logic [7:0] x);
    logic [7:0] sq;
    logic [7:0] inv;
    sq  = x;
    inv = 8'h01;
    for (int k = 1; k < 8; k++) begin
      sq  = gf_mul(sq, sq);
      inv = gf_mul(inv, sq);
    end
    return inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]} ^
           {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
  endfunction

endpackage

// File: rtl/aes_enc_sbox.sv
module aes_enc_sbox (
  input  logic [7:0] din,
  output logic [7:0] dout
);
  import aes_enc_pkg::*;
  assign dout = sub_byte(din);
endmodule

// File: rtl/aes_enc_round.sv
module aes_enc_round (
  input  logic [127:0] state_i,
  input  logic [127:0] rkey_i,
  input  logic         mix_en,
  output logic [127:0] state_o
);
  import aes_enc_pkg::*;

  localparam int NBYTES = 16;

  logic [7:0] sb [NBYTES];
  logic [7:0] sr [NBYTES];
  logic [7:0] mx [NBYTES];

  for (genvar g = 0; g < NBYTES; g++) begin : g_sbox
    aes_enc_sbox u_sbox (.din(state_i[127-8*g -: 8]), .dout(sb[g]));
  end

  always_comb begin
    for (int c = 0; c < 4; c++) begin
      for (int r = 0; r < 4; r++) begin
        sr[4*c+r] = sb[4*((c+r)%4)+r];
      end
    end
    for (int c = 0; c < 4; c++) begin
      mx[4*c+0] = gf_xtime(sr[4*c]) ^ gf_xtime(sr[4*c+1]) ^ sr[4*c+1] ^ sr[4*c+2] ^ sr[4*c+3];
      mx[4*c+1] = sr[4*c] ^ gf_xtime(sr[4*c+1]) ^ gf_xtime(sr[4*c+2]) ^ sr[4*c+2] ^ sr[4*c+3];
      mx[4*c+2] = sr[4*c] ^ sr[4*c+1] ^ gf_xtime(sr[4*c+2]) ^ gf_xtime(sr[4*c+3]) ^ sr[4*c+3];
      mx[4*c+3] = gf_xtime(sr[4*c]) ^ sr[4*c] ^ sr[4*c+1] ^ sr[4*c+2] ^ gf_xtime(sr[4*c+3]);
    end
    for (int i = 0; i < NBYTES; i++) begin
      state_o[127-8*i -: 8] = (mix_en ? mx[i] : sr[i]) ^ rkey_i[127-8*i -: 8];
    end
  end

endmodule

// File: rtl/aes_enc_ctrl.sv
module aes_enc_ctrl #(
  parameter int NR   = 10,
  parameter int IDXW = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  data_stable,
  input  logic                  key_stable,
  input  logic                  key_ready,
  output aes_enc_pkg::aes_st_e  st,
  output logic                  capture,
  output logic [IDXW-1:0]       rk_idx,
  output logic                  done
);
  import aes_enc_pkg::*;

  assign capture = (st == ST_IDLE) && data_stable && key_stable && key_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      rk_idx <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE:   if (capture) st <= ST_INIT;
        ST_INIT: begin
          st     <= ST_ROUNDS;
          rk_idx <= IDXW'(1);
        end
        ST_ROUNDS: begin
          rk_idx <= rk_idx + 1'b1;
          if (rk_idx == IDXW'(NR - 1)) st <= ST_LAST;
        end
        ST_LAST: begin
          st     <= ST_DONE;
          rk_idx <= '0;
          done   <= 1'b1;
        end
        ST_DONE:   st <= ST_IDLE;
        default:   st <= ST_IDLE;
      endcase
    end
  end

  AST_IDLE_GATE: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && !(data_stable && key_stable && key_ready)) |=> (st == ST_IDLE)); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R3
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ROUNDS) |=> (rk_idx == IDXW'($past(rk_idx) + 1'b1))); // R4
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
    rk_idx <= IDXW'(NR)); // R4
  AST_LAST_IDX: assert property (@(posedge clk) disable iff (rst)
    (st == ST_LAST) |-> (rk_idx == IDXW'(NR))); // R4

endmodule

// File: rtl/aes_enc_core.sv
module aes_enc_core #(
  parameter int KEY_BITS = 128,
  localparam int NR      = KEY_BITS / 32 + 6,
  localparam int IDXW    = $clog2(NR + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [127:0]    plaintext,
  input  logic            data_stable,
  input  logic            key_stable,
  input  logic            key_ready,
  input  logic [127:0]    round_key,
  output logic [IDXW-1:0] rk_idx,
  output logic [127:0]    result,
  output logic            done
);
  import aes_enc_pkg::*;

  aes_st_e      st;
  logic         capture;
  logic [127:0] state_q;
  logic [127:0] rnd_out;

  aes_enc_ctrl #(.NR(NR), .IDXW(IDXW)) u_ctrl (
    .clk(clk), .rst(rst),
    .data_stable(data_stable), .key_stable(key_stable), .key_ready(key_ready),
    .st(st), .capture(capture), .rk_idx(rk_idx), .done(done)
  );

  aes_enc_round u_round (
    .state_i(state_q), .rkey_i(round_key),
    .mix_en(st == ST_ROUNDS), .state_o(rnd_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= '0;
      result  <= '0;
    end else begin
      case (st)
        ST_IDLE:   if (capture) state_q <= plaintext;
        ST_INIT:   state_q <= state_q ^ round_key;
        ST_ROUNDS: state_q <= rnd_out;
        ST_LAST:   result  <= rnd_out;
        default:   ;
      endcase
    end
  end

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$rose(done) |-> $stable(result)); // R6
  AST_KEYSIZE: assert property (@(posedge clk) disable iff (rst)
    (KEY_BITS == 128 || KEY_BITS == 192 || KEY_BITS == 256) || !done); // R1

endmodule

// File: tb/aes_enc_core_tb.sv
module aes_enc_core_tb;
  localparam int KEY_BITS = 128;
  localparam int NR   = KEY_BITS / 32 + 6;
  localparam int NK   = KEY_BITS / 32;
  localparam int IDXW = $clog2(NR + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [127:0] plaintext = '0;
  logic data_stable = 1'b0, key_stable = 1'b0, key_ready = 1'b0;
  logic [127:0] round_key;
  logic [IDXW-1:0] rk_idx;
  logic [127:0] result;
  logic done;

  logic [127:0] rk_mem [NR+1];
  logic [7:0]   sbox_tab [256];
  int checks = 0, failures = 0;
  logic [31:0] seed = 32'h1234_5679;

  always #5 clk = ~clk;

  assign round_key = rk_mem[rk_idx];

  aes_enc_core #(.KEY_BITS(KEY_BITS)) u_dut (
    .clk(clk), .rst(rst), .plaintext(plaintext), .data_stable(data_stable),
    .key_stable(key_stable), .key_ready(key_ready), .round_key(round_key),
    .rk_idx(rk_idx), .result(result), .done(done)
  );

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] tmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = 8'h00;
    logic [7:0] x = a;
    logic [7:0] y = b;
    while (y != 0) begin
      if (y[0]) p ^= x;
      x = x[7] ? ((x << 1) ^ 8'h1b) : (x << 1);
      y = y >> 1;
    end
    return p;
  endfunction

  task automatic build_sbox();
    for (int x = 0; x < 256; x++) begin
      logic [7:0] inv = 8'h00;
      logic [7:0] s;
      for (int y = 1; y < 256; y++) if (tmul(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
      for (int i = 0; i < 8; i++)
        s[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ ((8'h63 >> i) & 1);
      sbox_tab[x] = s;
    end
  endtask

  function automatic logic [31:0] subw(input logic [31:0] w);
    return {sbox_tab[w[31:24]], sbox_tab[w[23:16]], sbox_tab[w[15:8]], sbox_tab[w[7:0]]};
  endfunction

  task automatic expand(input logic [255:0] key);
    logic [31:0] w [4*(NR+1)];
    logic [31:0] t;
    logic [7:0]  rc = 8'h01;
    for (int i = 0; i < 4*(NR+1); i++) begin
      if (i < NK) w[i] = key[255-32*i -: 32];
      else begin
        t = w[i-1];
        if (i % NK == 0) begin
          t = subw({t[23:0], t[31:24]}) ^ {rc, 24'h0};
          rc = tmul(rc, 8'h02);
        end else if (NK > 6 && i % NK == 4) t = subw(t);
        w[i] = w[i-NK] ^ t;
      end
    end
    for (int r = 0; r <= NR; r++) rk_mem[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
  endtask

  function automatic logic [127:0] ref_encrypt(input logic [127:0] pt);
    logic [127:0] v = pt ^ rk_mem[0];
    logic [7:0] t [16];
    logic [7:0] s [16];
    for (int rnd = 1; rnd <= NR; rnd++) begin
      for (int i = 0; i < 16; i++) t[i] = sbox_tab[v[127-8*i -: 8]];
      for (int c = 0; c < 4; c++)
        for (int r = 0; r < 4; r++) s[4*c+r] = t[4*((c+r)%4)+r];
      for (int c = 0; c < 4; c++)
        for (int r = 0; r < 4; r++)
          v[127-8*(4*c+r) -: 8] = (rnd == NR) ? s[4*c+r] :
            tmul(s[4*c+r], 8'h02) ^ tmul(s[4*c+(r+1)%4], 8'h03) ^ s[4*c+(r+2)%4] ^ s[4*c+(r+3)%4];
      v = v ^ rk_mem[rnd];
    end
    return v;
  endfunction

  function automatic logic [31:0] next_rand();
    seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
    return seed;
  endfunction

  // One block: start edge is k=0; samples at falling edges after edge k
  task automatic run_block(input logic [127:0] pt, input logic [127:0] exp);
    bit idx_ok = 1, done_ok = 1;
    @(negedge clk);
    plaintext = pt; data_stable = 1; key_stable = 1; key_ready = 1;
    for (int k = 0; k <= NR + 2; k++) begin
      @(negedge clk);
      if (k == 0) begin
        data_stable = 0; key_stable = 0; plaintext = ~pt; // R5 disturbance
      end
      if (k >= 1 && k <= NR && rk_idx != IDXW'(k)) idx_ok = 0;
      if (done != (k == NR + 1)) done_ok = 0;
      if (k == NR + 1) check(result == exp, "R1/R5 ciphertext", result, exp);
      if (k == NR + 2) check(rk_idx == 0, "R4 index back to 0", 128'(rk_idx), 0);
    end
    check(idx_ok, "R4 index sequence", 128'(rk_idx), 0);
    check(done_ok, "R3 done timing", 128'(done), 0);
  endtask

  task automatic idle_gate(input bit ds, input bit ks, input bit kr);
    bit ok = 1;
    @(negedge clk);
    data_stable = ds; key_stable = ks; key_ready = kr;
    repeat (12) begin
      @(negedge clk);
      if (done || rk_idx != 0) ok = 0;
    end
    data_stable = 0; key_stable = 0; key_ready = 1;
    check(ok, "R2 start gated", {rk_idx, done}, 0);
  endtask

  initial begin
    logic [255:0] key = '0;
    logic [127:0] fips_ct, held;
    case (KEY_BITS)
      192:     fips_ct = 128'hdda97ca4864cdfe06eaf70a0ec0d7191;
      256:     fips_ct = 128'h8ea2b7ca516745bfeafc49904b496089;
      default: fips_ct = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
    endcase
    build_sbox();
    for (int i = 0; i < KEY_BITS / 8; i++) key[255-8*i -: 8] = 8'(i);
    expand(key);
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    @(negedge clk);
    check(done == 0 && rk_idx == 0 && result == 0, "R7 reset state", result, 0);
    check(ref_encrypt(128'h00112233445566778899aabbccddeeff) == fips_ct, "R1 model anchor",
          ref_encrypt(128'h00112233445566778899aabbccddeeff), fips_ct);
    idle_gate(1, 1, 0);
    idle_gate(0, 1, 1);
    idle_gate(1, 0, 1);
    run_block(128'h00112233445566778899aabbccddeeff, fips_ct);
    held = result;
    repeat (20) begin
      @(negedge clk); plaintext = {next_rand(), next_rand(), next_rand(), next_rand()};
    end
    check(result == held, "R6 result held", result, held);
    run_block('0, ref_encrypt('0));
    run_block('1, ref_encrypt('1));
    for (int b = 0; b < 24; b++) begin
      logic [127:0] pt;
      if (b % 6 == 0) begin
        @(negedge clk) key_ready = 0;
        key = {next_rand(), next_rand(), next_rand(), next_rand(),
               next_rand(), next_rand(), next_rand(), next_rand()};
        expand(key);
      end
      pt = {next_rand(), next_rand(), next_rand(), next_rand()};
      run_block(pt, ref_encrypt(pt));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule